// File: doc/BRIEF.md
# Subroutine Call and Return Sequencer

This block is the multi-cycle control unit that carries out the control-transfer operations of a small 32-bit processor. These are register-indirect and PC-relative calls, a plain return, an interrupt return, a trap, a fast return through the link register, and a return that also restores a list of saved registers. Decode hands it an operation code with its operands and the current PC, SP and link register. The block then runs the memory traffic the operation needs over one request/acknowledge data port, and finishes with a single writeback cycle. In that cycle the new PC, SP, link register and status word are presented together with their write strobes.

Every call also copies its return address into the link register, so a later fast return can jump from it without a stack read. The restoring return reads descending word slots below the adjusted stack pointer. The general registers chosen by a 4-bit mask come first, in ascending index order, followed by seven fixed slots. Each restored word appears on a dedicated writeback port, tagged with its slot number.

The controller is a six-state machine:
- S_IDLE waits for `start`. From there it moves to S_PUSH (calls and trap), S_LDPC (plain return), S_LDPSW (interrupt return), S_RESTORE (restoring return) or straight to S_FINISH (no-op, fast return, unknown codes).
- S_PUSH goes to S_FINISH on acknowledge.
- S_LDPSW goes to S_LDPC on acknowledge.
- S_LDPC goes to S_FINISH on acknowledge.
- S_RESTORE loops on each acknowledge and goes to S_FINISH after the acknowledge of slot 10.
- S_FINISH always returns to S_IDLE.

Top module: `callret_seq`

## Requirements
- R1: While and right after reset, `busy`, `done`, `mem_req`, `rst_we` and all four writeback strobes are 0.
- R2: op=1 (indirect call) writes PC+2 to address SP-4, and ends with SP=SP-4, MDR=PC+2 and PC=`areg`.
- R3: op=2 (short relative call) writes PC+4 to SP-4, and ends with SP=SP-4, MDR=PC+4 and PC=PC+sign-extended `disp[15:0]`. Bits 31:16 of `disp` are ignored.
- R4: op=3 (long relative call) writes PC+6 to SP-4, and ends with SP=SP-4, MDR=PC+6 and PC=PC+`disp`.
- R5: op=4 (return) reads the word at SP and loads it into PC. SP, MDR and PSW are not written.
- R6: op=5 (interrupt return) makes a 16-bit read (`mem_half`=1) at SP, whose low 16 bits become PSW. It then reads the word at SP+4 into PC and ends with SP=SP+8.
- R7: op=6 (trap) writes PC+2 to address SP, and ends with PC=0x40000010. SP and MDR are not written.
- R8: op=7 (fast return) makes no memory request, and ends with SP=SP+zero-extended `imm8` and PC=MDR.
- R9: op=8 (restoring return) sets B=SP+zero-extended `imm8` and reads words at B-4, B-8, … in descending order. The slots are read in this order:
  - the general registers i whose `reg_mask[i]`=1, in ascending i, as slot numbers 0–3;
  - then slot numbers 4 to 10, in that order.
  Each read is presented once on `rst_data` with `rst_idx`=slot and `rst_we`=1. The operation ends with SP=B and PC=the `mdr_in` captured at start.
- R10: op=0 and unknown codes 9–15 write only PC=PC+1, with `done` one cycle after the start edge.
- R11: `busy` is high from the cycle after the start edge through the `done` cycle. `done` lasts one cycle, and writeback strobes rise only in the `done` cycle. An operation with N memory accesses completes 1+N·(L+2) cycles after start when every access is acknowledged L+2 cycles after its request rises.
- R12: A memory request holds its address, direction and size until acknowledged. Word accesses have address bits 1:0 = 0, given a word-aligned SP and `imm8`.
- R13: `start` is ignored while `busy` is high. The running operation completes unchanged and no second operation follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch the presented operation (sampled in idle) |
| op | input | 4 | Operation code |
| reg_mask | input | NUM_GPR | General registers to restore |
| imm8 | input | 8 | Stack adjust, zero-extended |
| disp | input | XLEN | Call displacement |
| areg | input | XLEN | Address register for indirect call |
| pc_in | input | XLEN | Current PC |
| sp_in | input | XLEN | Current SP |
| mdr_in | input | XLEN | Current link register |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_half | output | 1 | Request is a 16-bit read |
| mem_addr | output | XLEN | Byte address |
| mem_wdata | output | XLEN | Write data |
| mem_ack | input | 1 | Access complete |
| mem_rdata | input | XLEN | Read data, valid with ack |
| pc_we | output | 1 | PC writeback strobe |
| pc_out | output | XLEN | New PC |
| sp_we | output | 1 | SP writeback strobe |
| sp_out | output | XLEN | New SP |
| mdr_we | output | 1 | Link register writeback strobe |
| mdr_out | output | XLEN | New link register |
| psw_we | output | 1 | Status word writeback strobe |
| psw_out | output | 16 | New status word |
| rst_we | output | 1 | Restored-slot strobe |
| rst_idx | output | SLOT_W | Restored slot number |
| rst_data | output | XLEN | Restored value |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench memory acknowledges every request exactly L+2 cycles after it rises. A memory write is compared at the acknowledge edge, and a restored slot in the cycle its acknowledge is high. The final PC, SP, MDR and PSW values are compared in the `done` cycle, which must arrive 1+N·(L+2) cycles after the start edge for an operation with N accesses. Expected items are queued in issue order before each start, so a value arriving early, late, twice or not at all shows up as a mismatch or as a non-empty queue one cycle after `done`.

// File: rtl/callret_pkg.sv
package callret_pkg;

    localparam int unsigned FIXED_SLOTS = 7;

    typedef enum logic [3:0] {
        OP_NOP      = 4'd0,
        OP_CALL_IND = 4'd1,
        OP_CALL_D16 = 4'd2,
        OP_CALL_D32 = 4'd3,
        OP_RET      = 4'd4,
        OP_RETI     = 4'd5,
        OP_TRAP     = 4'd6,
        OP_RETF     = 4'd7,
        OP_RETR     = 4'd8
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PUSH,
        S_LDPSW,
        S_LDPC,
        S_RESTORE,
        S_FINISH
    } state_e;

endpackage

// File: rtl/callret_target.sv
module callret_target
    import callret_pkg::*;
#(
    parameter int unsigned     XLEN        = 32,
    parameter logic [XLEN-1:0] TRAP_VECTOR = 32'h4000_0010
) (
    input  op_e             op_i,
    input  logic [XLEN-1:0] pc_i,
    input  logic [XLEN-1:0] disp_i,
    input  logic [XLEN-1:0] areg_i,
    output logic [XLEN-1:0] ret_addr_o,
    output logic [XLEN-1:0] target_o
);

    logic [XLEN-1:0] disp_short;

    assign disp_short = {{(XLEN-16){disp_i[15]}}, disp_i[15:0]};

    always_comb begin
        unique case (op_i)
            OP_CALL_IND: begin
                ret_addr_o = pc_i + XLEN'(2);
                target_o   = areg_i;
            end
            OP_CALL_D16: begin
                ret_addr_o = pc_i + XLEN'(4);
                target_o   = pc_i + disp_short;
            end
            OP_CALL_D32: begin
                ret_addr_o = pc_i + XLEN'(6);
                target_o   = pc_i + disp_i;
            end
            OP_TRAP: begin
                ret_addr_o = pc_i + XLEN'(2);
                target_o   = TRAP_VECTOR;
            end
            default: begin
                ret_addr_o = pc_i + XLEN'(1);
                target_o   = pc_i + XLEN'(1);
            end
        endcase
    end

endmodule

// File: rtl/callret_slot_order.sv
module callret_slot_order #(
    parameter int unsigned NUM_GPR = 4,
    parameter int unsigned SLOT_W  = 4
) (
    input  logic [NUM_GPR-1:0] mask_i,
    input  logic [SLOT_W-1:0]  cur_i,
    output logic [SLOT_W-1:0]  first_o,
    output logic [SLOT_W-1:0]  next_o
);

    // Lowest selected general register, else the first fixed slot.
    always_comb begin
        first_o = SLOT_W'(NUM_GPR);
        for (int i = NUM_GPR - 1; i >= 0; i--) begin
            if (mask_i[i]) first_o = SLOT_W'(i);
        end
    end

    // Next selected general register above cur, else step through fixed slots.
    always_comb begin
        next_o = cur_i + SLOT_W'(1);
        if (cur_i < SLOT_W'(NUM_GPR)) begin
            next_o = SLOT_W'(NUM_GPR);
            for (int i = NUM_GPR - 1; i >= 0; i--) begin
                if (mask_i[i] && (SLOT_W'(i) > cur_i)) next_o = SLOT_W'(i);
            end
        end
    end

endmodule

// File: rtl/callret_seq.sv
module callret_seq
    import callret_pkg::*;
#(
    parameter int unsigned     XLEN        = 32,
    parameter int unsigned     NUM_GPR     = 4,
    parameter logic [XLEN-1:0] TRAP_VECTOR = 32'h4000_0010,
    localparam int unsigned    LAST_SLOT   = NUM_GPR + FIXED_SLOTS - 1,
    localparam int unsigned    SLOT_W      = $clog2(LAST_SLOT + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [3:0]         op,
    input  logic [NUM_GPR-1:0] reg_mask,
    input  logic [7:0]         imm8,
    input  logic [XLEN-1:0]    disp,
    input  logic [XLEN-1:0]    areg,
    input  logic [XLEN-1:0]    pc_in,
    input  logic [XLEN-1:0]    sp_in,
    input  logic [XLEN-1:0]    mdr_in,
    output logic               mem_req,
    output logic               mem_we,
    output logic               mem_half,
    output logic [XLEN-1:0]    mem_addr,
    output logic [XLEN-1:0]    mem_wdata,
    input  logic               mem_ack,
    input  logic [XLEN-1:0]    mem_rdata,
    output logic               pc_we,
    output logic [XLEN-1:0]    pc_out,
    output logic               sp_we,
    output logic [XLEN-1:0]    sp_out,
    output logic               mdr_we,
    output logic [XLEN-1:0]    mdr_out,
    output logic               psw_we,
    output logic [15:0]        psw_out,
    output logic               rst_we,
    output logic [SLOT_W-1:0]  rst_idx,
    output logic [XLEN-1:0]    rst_data,
    output logic               busy,
    output logic               done
);

    localparam int unsigned BYTES = XLEN / 8;

    state_e             state_q, state_d;
    op_e                op_in, op_q;
    logic [NUM_GPR-1:0] mask_q, mask_sel;
    logic [XLEN-1:0]    addr_q, wdata_q, pc_q, sp_q, mdr_q;
    logic [15:0]        psw_q;
    logic [SLOT_W-1:0]  slot_q, slot_first, slot_next;
    logic [XLEN-1:0]    ret_addr, target, sp_plus;
    logic               is_call;

    assign op_in    = op_e'(op);
    assign sp_plus  = sp_in + {{(XLEN-8){1'b0}}, imm8};
    assign mask_sel = (state_q == S_IDLE) ? reg_mask : mask_q;
    assign is_call  = (op_q == OP_CALL_IND) || (op_q == OP_CALL_D16) || (op_q == OP_CALL_D32);

    callret_target #(
        .XLEN        (XLEN),
        .TRAP_VECTOR (TRAP_VECTOR)
    ) u_target (
        .op_i       (op_in),
        .pc_i       (pc_in),
        .disp_i     (disp),
        .areg_i     (areg),
        .ret_addr_o (ret_addr),
        .target_o   (target)
    );

    callret_slot_order #(
        .NUM_GPR (NUM_GPR),
        .SLOT_W  (SLOT_W)
    ) u_slot (
        .mask_i  (mask_sel),
        .cur_i   (slot_q),
        .first_o (slot_first),
        .next_o  (slot_next)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (start) begin
                    unique case (op_in)
                        OP_CALL_IND, OP_CALL_D16, OP_CALL_D32, OP_TRAP: state_d = S_PUSH;
                        OP_RET:  state_d = S_LDPC;
                        OP_RETI: state_d = S_LDPSW;
                        OP_RETR: state_d = S_RESTORE;
                        default: state_d = S_FINISH;
                    endcase
                end
            end
            S_PUSH:    if (mem_ack) state_d = S_FINISH;
            S_LDPSW:   if (mem_ack) state_d = S_LDPC;
            S_LDPC:    if (mem_ack) state_d = S_FINISH;
            S_RESTORE: if (mem_ack && (slot_q == SLOT_W'(LAST_SLOT))) state_d = S_FINISH;
            S_FINISH:  state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // Operand and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q    <= OP_NOP;
            mask_q  <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            pc_q    <= '0;
            sp_q    <= '0;
            mdr_q   <= '0;
            psw_q   <= '0;
            slot_q  <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (start) begin
                        op_q    <= op_in;
                        mask_q  <= reg_mask;
                        slot_q  <= slot_first;
                        mdr_q   <= ret_addr;
                        wdata_q <= ret_addr;
                        pc_q    <= target;
                        sp_q    <= sp_in;
                        addr_q  <= sp_in;
                        psw_q   <= '0;
                        unique case (op_in)
                            OP_CALL_IND, OP_CALL_D16, OP_CALL_D32: begin
                                addr_q <= sp_in - XLEN'(BYTES);
                                sp_q   <= sp_in - XLEN'(BYTES);
                            end
                            OP_RETI: sp_q <= sp_in + XLEN'(2 * BYTES);
                            OP_RETF: begin
                                sp_q <= sp_plus;
                                pc_q <= mdr_in;
                            end
                            OP_RETR: begin
                                sp_q   <= sp_plus;
                                pc_q   <= mdr_in;
                                addr_q <= sp_plus - XLEN'(BYTES);
                            end
                            default: ;
                        endcase
                    end
                end
                S_LDPSW: begin
                    if (mem_ack) begin
                        psw_q  <= mem_rdata[15:0];
                        addr_q <= addr_q + XLEN'(BYTES);
                    end
                end
                S_LDPC: if (mem_ack) pc_q <= mem_rdata;
                S_RESTORE: begin
                    if (mem_ack) begin
                        slot_q <= slot_next;
                        addr_q <= addr_q - XLEN'(BYTES);
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    assign busy = (state_q != S_IDLE);

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_half  = 1'b0;
        mem_addr  = addr_q;
        mem_wdata = wdata_q;
        pc_we     = 1'b0;
        sp_we     = 1'b0;
        mdr_we    = 1'b0;
        psw_we    = 1'b0;
        pc_out    = pc_q;
        sp_out    = sp_q;
        mdr_out   = mdr_q;
        psw_out   = psw_q;
        rst_we    = 1'b0;
        rst_idx   = slot_q;
        rst_data  = mem_rdata;
        done      = 1'b0;
        unique case (state_q)
            S_IDLE: ;
            S_PUSH: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
            S_LDPSW: begin
                mem_req  = 1'b1;
                mem_half = 1'b1;
            end
            S_LDPC: mem_req = 1'b1;
            S_RESTORE: begin
                mem_req = 1'b1;
                rst_we  = mem_ack;
            end
            S_FINISH: begin
                done   = 1'b1;
                pc_we  = 1'b1;
                sp_we  = is_call || (op_q == OP_RETI) || (op_q == OP_RETF) || (op_q == OP_RETR);
                mdr_we = is_call;
                psw_we = (op_q == OP_RETI);
            end
            default: ;
        endcase
    end

    // Checks
    a_r11_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r11_we_only_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_we || sp_we || mdr_we || psw_we) |-> done);

    a_r12_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_half)));

    a_r12_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_half) |-> (mem_addr[1:0] == 2'b00));

    a_r9_slot_ascends: assert property (@(posedge clk) disable iff (!rst_n)
        rst_we |=> (done || (rst_idx > $past(rst_idx))));

    a_r13_no_mem_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

endmodule

// File: tb/test_callret_seq.sv
module test_callret_seq;
    import callret_pkg::*;

    localparam int LAT = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  op = 4'd0;
    logic [3:0]  reg_mask = 4'd0;
    logic [7:0]  imm8 = 8'd0;
    logic [31:0] disp = '0, areg = '0, pc_in = '0, sp_in = '0, mdr_in = '0;
    logic        mem_req, mem_we, mem_half, mem_ack = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
    logic        pc_we, sp_we, mdr_we, psw_we, rst_we, busy, done;
    logic [31:0] pc_out, sp_out, mdr_out, rst_data;
    logic [15:0] psw_out;
    logic [3:0]  rst_idx;

    always #10 clk = ~clk;

    callret_seq i_callret_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .reg_mask(reg_mask),
        .imm8(imm8), .disp(disp), .areg(areg), .pc_in(pc_in), .sp_in(sp_in),
        .mdr_in(mdr_in), .mem_req(mem_req), .mem_we(mem_we), .mem_half(mem_half),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .pc_we(pc_we), .pc_out(pc_out), .sp_we(sp_we),
        .sp_out(sp_out), .mdr_we(mdr_we), .mdr_out(mdr_out), .psw_we(psw_we),
        .psw_out(psw_out), .rst_we(rst_we), .rst_idx(rst_idx), .rst_data(rst_data),
        .busy(busy), .done(done)
    );

    // Kinds: 0 PC, 1 SP, 2 MDR, 3 PSW, 4 restored slot (idx=slot), 5 memory write (idx=addr)
    typedef struct {
        int          kind;
        int          idx;
        logic [31:0] val;
        string       req;
    } ev_t;

    ev_t         exp_q[$];
    int          n_chk = 0;
    int          n_bad = 0;
    int          req_cycles = 0;
    int          ack_cnt = 0;
    logic [31:0] mem [int unsigned];

    function automatic logic [31:0] mem_rd(input logic [31:0] a);
        if (mem.exists(a)) return mem[a];
        return {a[15:0], ~a[15:0]} ^ 32'h1357_9bdf;
    endfunction

    function automatic void check(input bit ok, input string req, input string what,
                                  input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endfunction

    function automatic void sb_push(input int kind, input int idx, input logic [31:0] val,
                                    input string req);
        ev_t e;
        e.kind = kind; e.idx = idx; e.val = val; e.req = req;
        exp_q.push_back(e);
    endfunction

    function automatic void observe(input int kind, input int idx, input logic [31:0] val);
        ev_t e;
        n_chk++;
        if (exp_q.size() == 0) begin
            n_bad++;
            $display("FAIL R11 unexpected item kind %0d idx %0h: actual %h expected none",
                     kind, idx, val);
            return;
        end
        e = exp_q.pop_front();
        if (e.kind != kind || e.idx != idx || e.val !== val) begin
            n_bad++;
            $display("FAIL %s kind %0d/%0d idx %0h/%0h: actual %h expected %h",
                     e.req, kind, e.kind, idx, e.idx, val, e.val);
        end
    endfunction

    // Memory model: acknowledge LAT+2 cycles after a request rises
    always @(posedge clk) begin
        logic [31:0] w;
        if (!rst_n) begin
            mem_ack <= 1'b0;
            ack_cnt <= 0;
        end else begin
            mem_ack <= 1'b0;
            if (mem_req) req_cycles++;
            if (mem_req && !mem_ack) begin
                if (ack_cnt == LAT) begin
                    mem_ack <= 1'b1;
                    ack_cnt <= 0;
                    if (mem_we) begin
                        mem[mem_addr] = mem_wdata;
                        observe(5, int'(mem_addr), mem_wdata);
                    end else begin
                        w = mem_rd(mem_addr);
                        mem_rdata <= mem_half ? {16'h0, w[15:0]} : w;
                    end
                end else begin
                    ack_cnt <= ack_cnt + 1;
                end
            end
        end
    end

    // Monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (rst_we) observe(4, int'(rst_idx), rst_data);
            if (done) begin
                if (pc_we)  observe(0, 0, pc_out);
                if (sp_we)  observe(1, 0, sp_out);
                if (mdr_we) observe(2, 0, mdr_out);
                if (psw_we) observe(3, 0, {16'h0, psw_out});
            end
        end
    end

    function automatic void summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL R11 watchdog: actual hung expected completion");
        summary();
        $finish;
    end

    task automatic run_op(input logic [3:0] o, input logic [3:0] m, input logic [7:0] im,
                          input logic [31:0] d, input logic [31:0] a, input logic [31:0] p,
                          input logic [31:0] s, input logic [31:0] md, input int n_acc,
                          input bit poke, input string req);
        int cyc;
        bit busy_ok;
        @(negedge clk);
        op = o; reg_mask = m; imm8 = im; disp = d; areg = a; pc_in = p; sp_in = s; mdr_in = md;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        busy_ok = 1'b1;
        while (!done) begin
            if (!busy) busy_ok = 1'b0;
            if (poke && cyc == 2) begin
                start = 1'b1;
                op = OP_NOP;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        if (!busy) busy_ok = 1'b0;
        check(busy_ok, "R11", "busy through operation", 32'(busy_ok), 32'd1);
        check(cyc == 1 + n_acc * (LAT + 2), "R11", {req, " done latency"},
              32'(cyc), 32'(1 + n_acc * (LAT + 2)));
        @(negedge clk);
        check(!busy && !done, "R11", "idle after done", {30'd0, busy, done}, 32'd0);
        check(exp_q.size() == 0, req, "pending expected items", 32'(exp_q.size()), 32'd0);
        if (poke) begin
            repeat (3) begin
                @(negedge clk);
                check(!done && !busy, "R13", "no second operation", {30'd0, busy, done}, 32'd0);
            end
        end
    endtask

    task automatic plan_restore(input logic [3:0] m, input logic [31:0] base);
        logic [31:0] a;
        a = base;
        for (int g = 0; g < 4; g++) begin
            if (m[g]) begin
                a = a - 32'd4;
                sb_push(4, g, mem_rd(a), "R9");
            end
        end
        for (int f = 4; f <= 10; f++) begin
            a = a - 32'd4;
            sb_push(4, f, mem_rd(a), "R9");
        end
    endtask

    initial begin
        int rc;
        // R1: reset state
        repeat (3) @(negedge clk);
        check({busy, done, mem_req, rst_we, pc_we, sp_we, mdr_we, psw_we} == 8'd0, "R1",
              "outputs in reset", {24'd0, busy, done, mem_req, rst_we, pc_we, sp_we, mdr_we, psw_we}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check({busy, done, mem_req, pc_we} == 4'd0, "R1", "outputs after reset",
              {28'd0, busy, done, mem_req, pc_we}, 32'd0);

        // R10: no-op
        sb_push(0, 0, 32'h0000_0101, "R10");
        run_op(OP_NOP, 4'h0, 8'h0, '0, '0, 32'h100, 32'h8000, 32'h0, 0, 1'b0, "R10");

        // R10: unknown code behaves as no-op
        sb_push(0, 0, 32'h0000_0201, "R10");
        run_op(4'd13, 4'h0, 8'h0, '0, '0, 32'h200, 32'h8000, 32'h0, 0, 1'b0, "R10");

        // R2: indirect call
        sb_push(5, 32'h7ffc, 32'h0000_1002, "R2");
        sb_push(0, 0, 32'h0000_2000, "R2");
        sb_push(1, 0, 32'h0000_7ffc, "R2");
        sb_push(2, 0, 32'h0000_1002, "R2");
        run_op(OP_CALL_IND, 4'h0, 8'h0, 32'hdead_beef, 32'h2000, 32'h1000, 32'h8000, 32'h0, 1, 1'b0, "R2");

        // R3: short call, negative displacement, upper disp bits ignored
        sb_push(5, 32'h7ffc, 32'h0000_3004, "R3");
        sb_push(0, 0, 32'h0000_2ff0, "R3");
        sb_push(1, 0, 32'h0000_7ffc, "R3");
        sb_push(2, 0, 32'h0000_3004, "R3");
        run_op(OP_CALL_D16, 4'h0, 8'h0, 32'h1234_fff0, '0, 32'h3000, 32'h8000, 32'h0, 1, 1'b0, "R3");

        // R4: long call
        sb_push(5, 32'h7ffc, 32'h0000_3006, "R4");
        sb_push(0, 0, 32'h0001_3000, "R4");
        sb_push(1, 0, 32'h0000_7ffc, "R4");
        sb_push(2, 0, 32'h0000_3006, "R4");
        run_op(OP_CALL_D32, 4'h0, 8'h0, 32'h0001_0000, '0, 32'h3000, 32'h8000, 32'h0, 1, 1'b0, "R4");

        // R5: plain return reads the word pushed by the previous call
        sb_push(0, 0, 32'h0000_3006, "R5");
        run_op(OP_RET, 4'h0, 8'h0, '0, '0, 32'h5000, 32'h7ffc, 32'h0, 1, 1'b0, "R5");

        // R6: interrupt return
        mem[32'h9000] = 32'habcd_5a5a;
        mem[32'h9004] = 32'h0004_4000;
        sb_push(0, 0, 32'h0004_4000, "R6");
        sb_push(1, 0, 32'h0000_9008, "R6");
        sb_push(3, 0, 32'h0000_5a5a, "R6");
        run_op(OP_RETI, 4'h0, 8'h0, '0, '0, 32'h100, 32'h9000, 32'h0, 2, 1'b0, "R6");

        // R7: trap
        sb_push(5, 32'h8800, 32'h0000_0502, "R7");
        sb_push(0, 0, 32'h4000_0010, "R7");
        run_op(OP_TRAP, 4'h0, 8'h0, '0, '0, 32'h500, 32'h8800, 32'h0, 1, 1'b0, "R7");

        // R8: fast return, no memory traffic
        rc = req_cycles;
        sb_push(0, 0, 32'h1234_5678, "R8");
        sb_push(1, 0, 32'h0000_7024, "R8");
        run_op(OP_RETF, 4'h0, 8'h24, '0, '0, 32'h100, 32'h7000, 32'h1234_5678, 0, 1'b0, "R8");
        check(req_cycles == rc, "R8", "memory request cycles", 32'(req_cycles - rc), 32'd0);

        // R9: restoring return, partial mask
        plan_restore(4'b0101, 32'h6010);
        sb_push(0, 0, 32'hcafe_0000, "R9");
        sb_push(1, 0, 32'h0000_6010, "R9");
        run_op(OP_RETR, 4'b0101, 8'h10, '0, '0, 32'h100, 32'h6000, 32'hcafe_0000, 9, 1'b0, "R9");

        // R9: empty mask, fixed slots only
        plan_restore(4'b0000, 32'h5000);
        sb_push(0, 0, 32'h0000_abc0, "R9");
        sb_push(1, 0, 32'h0000_5000, "R9");
        run_op(OP_RETR, 4'b0000, 8'h00, '0, '0, 32'h100, 32'h5000, 32'h0000_abc0, 7, 1'b0, "R9");

        // R9: full mask
        plan_restore(4'b1111, 32'h40fc);
        sb_push(0, 0, 32'h0000_0444, "R9");
        sb_push(1, 0, 32'h0000_40fc, "R9");
        run_op(OP_RETR, 4'b1111, 8'hfc, '0, '0, 32'h100, 32'h4000, 32'h0000_0444, 11, 1'b0, "R9");

        // R13: start raised mid-operation is ignored
        mem[32'h7100] = 32'h0000_0880;
        sb_push(0, 0, 32'h0000_0880, "R13");
        run_op(OP_RET, 4'h0, 8'h0, '0, '0, 32'h100, 32'h7100, 32'h0, 1, 1'b1, "R13");

        summary();
        $finish;
    end

endmodule